// File: doc/BRIEF.md
# Grouped-Priority Channel Allocator

This block hands out physical channels from a pool of up to 32. It keeps one busy bit per channel. When a client raises an allocation request, the block picks a free channel in the same cycle. It reports the chosen index with a success flag, or it raises a failure flag when nothing is free. The chosen channel is marked busy at the next clock edge. A separate release port returns a channel to the pool by its index.

Channels are not handed out in plain index order. Each channel has a priority level given by bits [3:2] of its index, so the lower sixteen and the upper sixteen channels interleave across four levels. The search takes the lowest level that has a free channel, and within that level it takes the lowest free index. A smaller pool, set by a parameter, searches only the levels its channels reach. The block does not queue requests and does not move data: it only decides which channel a request gets and tracks who holds what.

Top module: `challoc_top`

## Requirements
- R1: After a synchronous active-high reset every busy bit is clear, and with no request neither the success flag nor the failure flag is asserted.
- R2: A channel's level is bits [3:2] of its index. A request takes a channel from the lowest level that has a free channel. With all 32 channels free, successive grants are 0,1,2,3,16,17,18,19,4,…,7,20,…,23,8,…,11,24,…,27,12,…,15,28,…,31.
- R3: Within the chosen level the lowest free index is granted, and a granted index is always free or being released in that cycle.
- R4: A successful grant is reported in the cycle of the request. The granted channel's busy bit is set from the following cycle on.
- R5: When no channel is free, a request asserts the failure flag, leaves the success flag low and changes no busy bit. The two flags are never high together.
- R6: A release clears the channel's busy bit at the next edge. A request in the same cycle as a release may be granted the released channel, and that channel then stays busy.
- R7: Releasing a channel that is already free, or an index at or beyond the channel count, changes no busy bit.
- R8: A cycle with no request asserts neither flag and sets no busy bit.
- R9: With a configured count below 16, only the existing channels are granted, in ascending order, and the request after the last one fails.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| alloc_req_i | input | 1 | Request one free channel this cycle |
| free_req_i | input | 1 | Release the channel named by free_idx_i |
| free_idx_i | input | IDX_W | Index of the channel to release |
| alloc_ok_o | output | 1 | A channel was granted this cycle |
| alloc_idx_o | output | IDX_W | Index of the granted channel |
| alloc_fail_o | output | 1 | Request made while no channel was free |
| busy_map_o | output | N | One bit per channel, set while the channel is held |

## Verification
The full 32-channel pool is drained from empty, so the grant sequence shows whether the level order from bits [3:2] is applied rather than plain ascending order. Scattered releases across different levels, and pairs in the same level from both halves, are then refilled. This separates level-first choice from lowest-index choice within a level. Release and request in one cycle on a full pool tests whether the release is applied first. Redundant and out-of-range releases, plus a 10-channel instance drained to failure, cover the no-effect cases and the reduced level range.

// File: rtl/challoc_pkg.sv
package challoc_pkg;

    localparam int MAX_CH    = 32;
    localparam int MAX_IDX_W = 5;
    localparam int NUM_LVLS  = 4;

    typedef struct packed {
        logic                 hit;
        logic [MAX_IDX_W-1:0] idx;
    } level_pick_t;

    function automatic int lvl_of(input int ch);
        return (ch >> 2) & 3;
    endfunction

    function automatic int top_lvl(input int count);
        return ((count - 1) & 15) >> 2;
    endfunction

endpackage

// File: rtl/challoc_level_scan.sv
module challoc_level_scan
    import challoc_pkg::*;
#(
    parameter int N   = 32,
    parameter int LVL = 0
) (
    input  logic [N-1:0] free_vec_i,
    output level_pick_t  pick_o
);

    always_comb begin
        pick_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (lvl_of(i) == LVL && free_vec_i[i]) begin
                pick_o.hit = 1'b1;
                pick_o.idx = MAX_IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/challoc_select.sv
module challoc_select
    import challoc_pkg::*;
#(
    parameter int N = 32
) (
    input  logic [N-1:0] free_vec_i,
    output level_pick_t  pick_o
);

    localparam int ACTIVE_LVLS = top_lvl(N) + 1;

    level_pick_t lvl_pick [ACTIVE_LVLS];

    generate
        for (genvar l = 0; l < ACTIVE_LVLS; l++) begin : g_lvl
            challoc_level_scan #(.N(N), .LVL(l)) scan_i (
                .free_vec_i (free_vec_i),
                .pick_o     (lvl_pick[l])
            );
        end
    endgenerate

    always_comb begin
        pick_o = '0;
        for (int l = ACTIVE_LVLS - 1; l >= 0; l--) begin
            if (lvl_pick[l].hit) pick_o = lvl_pick[l];
        end
    end

endmodule

// File: rtl/challoc_busy_reg.sv
module challoc_busy_reg #(
    parameter int N = 32
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [N-1:0] clr_mask_i,
    input  logic [N-1:0] set_mask_i,
    output logic [N-1:0] busy_o
);

    always_ff @(posedge clk_i) begin
        if (rst_i) busy_o <= '0;
        else       busy_o <= (busy_o & ~clr_mask_i) | set_mask_i;
    end

endmodule

// File: rtl/challoc_top.sv
module challoc_top
    import challoc_pkg::*;
#(
    parameter int N     = 32,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             alloc_req_i,
    input  logic             free_req_i,
    input  logic [IDX_W-1:0] free_idx_i,
    output logic             alloc_ok_o,
    output logic [IDX_W-1:0] alloc_idx_o,
    output logic             alloc_fail_o,
    output logic [N-1:0]     busy_map_o
);

    logic [N-1:0] rel_mask;
    logic [N-1:0] grant_mask;
    logic [N-1:0] free_vec;
    level_pick_t  pick;

    // Release is applied before the search so a freed channel is eligible at once.
    always_comb begin
        rel_mask = '0;
        if (free_req_i && int'(free_idx_i) < N) rel_mask[free_idx_i] = 1'b1;
    end

    assign free_vec = ~busy_map_o | rel_mask;

    challoc_select #(.N(N)) sel_i (
        .free_vec_i (free_vec),
        .pick_o     (pick)
    );

    assign alloc_ok_o   = alloc_req_i && pick.hit;
    assign alloc_fail_o = alloc_req_i && !pick.hit;
    assign alloc_idx_o  = pick.idx[IDX_W-1:0];

    always_comb begin
        grant_mask = '0;
        if (alloc_ok_o) grant_mask[alloc_idx_o] = 1'b1;
    end

    challoc_busy_reg #(.N(N)) busy_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .clr_mask_i (rel_mask),
        .set_mask_i (grant_mask),
        .busy_o     (busy_map_o)
    );

endmodule

// File: rtl/challoc_chk.sv
module challoc_chk #(
    parameter int N     = 32,
    parameter int IDX_W = 5
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             alloc_req_i,
    input logic             free_req_i,
    input logic [IDX_W-1:0] free_idx_i,
    input logic             alloc_ok_o,
    input logic [IDX_W-1:0] alloc_idx_o,
    input logic             alloc_fail_o,
    input logic [N-1:0]     busy_map_o
);

    AST_RESET_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(rst_i) |-> busy_map_o == '0); // R1

    AST_GRANT_FREE: assert property (@(posedge clk_i) disable iff (rst_i)
        alloc_ok_o |-> (!busy_map_o[alloc_idx_o] ||
                        (free_req_i && free_idx_i == alloc_idx_o))); // R3

    AST_MARK_BUSY: assert property (@(posedge clk_i) disable iff (rst_i)
        alloc_ok_o |=> busy_map_o[$past(alloc_idx_o)]); // R4

    AST_FAIL_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        alloc_fail_o |=> busy_map_o == $past(busy_map_o)); // R5

    AST_FLAG_EXCL: assert property (@(posedge clk_i) disable iff (rst_i)
        !(alloc_ok_o && alloc_fail_o)); // R5

    AST_RELEASE_CLR: assert property (@(posedge clk_i) disable iff (rst_i)
        (free_req_i && int'(free_idx_i) < N &&
         !(alloc_ok_o && alloc_idx_o == free_idx_i))
        |=> !busy_map_o[$past(free_idx_i)]); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        !alloc_req_i |-> (!alloc_ok_o && !alloc_fail_o)); // R8

endmodule

bind challoc_top challoc_chk #(.N(N), .IDX_W(IDX_W)) chk_i (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .alloc_req_i  (alloc_req_i),
    .free_req_i   (free_req_i),
    .free_idx_i   (free_idx_i),
    .alloc_ok_o   (alloc_ok_o),
    .alloc_idx_o  (alloc_idx_o),
    .alloc_fail_o (alloc_fail_o),
    .busy_map_o   (busy_map_o)
);

// File: tb/challoc_top_tb_top.sv
module challoc_top_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    // full-size instance
    logic        req = 1'b0, rel = 1'b0;
    logic [4:0]  rel_idx = '0;
    logic        ok, fail;
    logic [4:0]  gidx;
    logic [31:0] busy;

    // 10-channel instance
    logic        req_s = 1'b0, rel_s = 1'b0;
    logic [3:0]  rel_idx_s = '0;
    logic        ok_s, fail_s;
    logic [3:0]  gidx_s;
    logic [9:0]  busy_s;

    challoc_top dut_i (
        .clk_i(clk), .rst_i(rst), .alloc_req_i(req), .free_req_i(rel),
        .free_idx_i(rel_idx), .alloc_ok_o(ok), .alloc_idx_o(gidx),
        .alloc_fail_o(fail), .busy_map_o(busy)
    );

    challoc_top #(.N(10)) dut_s (
        .clk_i(clk), .rst_i(rst), .alloc_req_i(req_s), .free_req_i(rel_s),
        .free_idx_i(rel_idx_s), .alloc_ok_o(ok_s), .alloc_idx_o(gidx_s),
        .alloc_fail_o(fail_s), .busy_map_o(busy_s)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic        c_ok, c_fail;
    logic [4:0]  c_idx;
    logic        cs_ok, cs_fail;
    logic [3:0]  cs_idx;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Model: rank = level*64 + index, pick the smallest free rank.
    function automatic int model_pick(input logic [31:0] b, input int n);
        int best = -1, best_rank = 1000;
        for (int i = 0; i < n; i++) begin
            int rank = ((i / 4) % 4) * 64 + i;
            if (!b[i] && rank < best_rank) begin best = i; best_rank = rank; end
        end
        return best;
    endfunction

    task automatic step(input logic r, input logic f, input int fi);
        @(negedge clk);
        req = r; rel = f; rel_idx = 5'(fi);
        #1;
        c_ok = ok; c_fail = fail; c_idx = gidx;
        @(posedge clk); #1;
        req = 1'b0; rel = 1'b0;
    endtask

    task automatic step_s(input logic r, input logic f, input int fi);
        @(negedge clk);
        req_s = r; rel_s = f; rel_idx_s = 4'(fi);
        #1;
        cs_ok = ok_s; cs_fail = fail_s; cs_idx = gidx_s;
        @(posedge clk); #1;
        req_s = 1'b0; rel_s = 1'b0;
    endtask

    task automatic t_reset;
        #1;
        chk("R1 busy after reset", busy, 0);
        chk("R1 no ok idle", ok, 0);
        chk("R8 no fail idle", fail, 0);
        step(0, 0, 0);
        chk("R8 idle keeps busy", busy, 0);
    endtask

    task automatic t_fill;
        int order [5] = '{0, 1, 2, 3, 16};
        logic [31:0] exp_busy = '0;
        for (int k = 0; k < 32; k++) begin
            int e = model_pick(exp_busy, 32);
            step(1, 0, 0);
            if (k < 5) chk("R2 early order", c_idx, order[k]);
            chk("R2 grant ok", c_ok, 1);
            chk("R3 grant index", c_idx, e);
            exp_busy[e] = 1'b1;
            chk("R4 busy after grant", busy, exp_busy);
        end
        step(1, 0, 0);
        chk("R5 fail flag", c_fail, 1);
        chk("R5 no ok on full", c_ok, 0);
        chk("R5 busy unchanged", busy, 32'hFFFF_FFFF);
    endtask

    task automatic t_release;
        step(0, 1, 5);
        chk("R6 release clears", busy, 32'hFFFF_FFDF);
        step(1, 0, 0);
        chk("R6 freed regranted", c_idx, 5);
        chk("R6 ok", c_ok, 1);
        step(1, 1, 20);
        chk("R6 same-cycle ok", c_ok, 1);
        chk("R6 same-cycle idx", c_idx, 20);
        chk("R6 stays busy", busy, 32'hFFFF_FFFF);
    endtask

    task automatic t_ignore;
        step(0, 1, 9);
        chk("R6 release 9", busy, 32'hFFFF_FDFF);
        step(0, 1, 9);
        chk("R7 double release", busy, 32'hFFFF_FDFF);
        step(1, 0, 0);
        chk("R3 refill 9", c_idx, 9);
    endtask

    task automatic t_pattern;
        step(0, 1, 30); step(0, 1, 2); step(0, 1, 25);
        step(1, 0, 0); chk("R2 level0 first", c_idx, 2);
        step(1, 0, 0); chk("R2 level2 next", c_idx, 25);
        step(1, 0, 0); chk("R2 level3 last", c_idx, 30);
        step(0, 1, 17); step(0, 1, 1);
        step(1, 0, 0); chk("R3 lowest in level", c_idx, 1);
        step(1, 0, 0); chk("R3 upper half next", c_idx, 17);
        chk("R4 full again", busy, 32'hFFFF_FFFF);
    endtask

    task automatic t_small;
        for (int k = 0; k < 10; k++) begin
            step_s(1, 0, 0);
            chk("R9 small order", cs_idx, k);
            chk("R9 small ok", cs_ok, 1);
        end
        step_s(1, 0, 0);
        chk("R9 small fail", cs_fail, 1);
        step_s(0, 1, 12);
        chk("R7 out of range release", busy_s, 10'h3FF);
        step_s(0, 1, 7);
        chk("R6 small release", busy_s, 10'h37F);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset;
        t_fill;
        t_release;
        t_ignore;
        t_pattern;
        t_small;
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule